// File: doc/BRIEF.md
# Multi-Mode Controller Timer

This block is a timer in the style of an industrial logic controller. It has one timing register that counts time-base ticks. A mode input chooses how that register behaves: delayed switch-on, delayed switch-off, a one-shot pulse of fixed width, or an accumulating timer that keeps its value. The register compares itself against a preset value and drives a single timer output.

The surrounding logic supplies three things. The first is a one-cycle `tick` strobe at the chosen time base. The second is an enable that also acts as the reset of the timer. The third is the controlled input signal. The output and the elapsed count are both registered. Each one changes on the clock edge that samples the causing inputs.

Top module: `plc_timer`

## Requirements
- R1: While `enable` is low, on the next edge `elapsed` becomes 0 and `done` becomes 0, whatever `run_in`, `tick` and `mode` are.
- R2: `elapsed` increases by exactly one, and only on an edge where `tick` is high. It never passes `preset`; at `preset` it saturates and does not wrap.
- R3: With mode 0 (on-delay), `done` rises on the edge where `elapsed` reaches `preset` while `run_in` is high. On any edge that samples `run_in` low, `done` and `elapsed` become 0, so a high pulse shorter than the preset gives no output.
- R4: With mode 1 (off-delay), an edge that samples `run_in` high sets `done` and clears `elapsed`. With `run_in` low after that, `elapsed` counts ticks and `done` falls on the edge where `elapsed` reaches `preset`. A shorter low gap leaves `done` high.
- R5: With mode 2 (fixed pulse), a rising `run_in` clears `elapsed` and sets `done`. `done` stays high until the edge where `elapsed` reaches `preset`, whatever the input does meanwhile. `elapsed` then holds.
- R6: With mode 2, a rising `run_in` while the pulse is still active neither restarts nor lengthens it.
- R7: With mode 3 (retentive), `elapsed` holds its value while `run_in` is low and resumes from it when `run_in` is high again. `done` is high while `elapsed` has reached `preset`, and only `enable` low clears it.
- R8: With `preset` 0, mode 0 raises `done` on the first edge that samples `run_in` high, and mode 1 drops it on the first edge that samples `run_in` low. No tick is needed in either case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle time-base strobe |
| enable | input | 1 | High lets the timer run; low clears it |
| run_in | input | 1 | Controlled input signal |
| preset | input | CNT_W | Terminal count |
| mode | input | 2 | 0 on-delay, 1 off-delay, 2 fixed pulse, 3 retentive |
| done | output | 1 | Timer output |
| elapsed | output | CNT_W | Current timing register value |

## Verification
Some rules hold on every cycle, and the assertions check these. Clearing under a low enable is one. Another is that the count moves only on a tick, or else drops to zero. The count never passes the preset. The on-delay output drops as soon as the input falls, the off-delay output is set while the input is high, and the retentive count holds while the input is low.

Other behaviour depends on a history of several edges, so only the scenario-driven bench can show it. This covers the exact edge where each mode's output rises or falls. It covers short pulses and gaps being filtered out, a new rising edge during an active pulse being ignored, a count resuming after a pause, and the behaviour with a preset of zero.

// File: rtl/plc_timer_pkg.sv
package plc_timer_pkg;
    typedef enum logic [1:0] {
        TM_ON_DLY  = 2'd0,
        TM_OFF_DLY = 2'd1,
        TM_PULSE   = 2'd2,
        TM_RETAIN  = 2'd3
    } tmr_mode_e;
endpackage

// File: rtl/plc_timer_edge.sv
module plc_timer_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= level;
    end

    assign rise = level & ~prev_q;
endmodule

// File: rtl/plc_timer_satinc.sv
module plc_timer_satinc #(
    parameter int CNT_W = 8
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] limit,
    input  logic             step,
    output logic [CNT_W-1:0] nxt,
    output logic             at_limit
);
    logic below;

    always_comb begin
        below    = (cnt < limit);
        nxt      = (step && below) ? cnt + CNT_W'(1) : cnt;
        at_limit = (nxt >= limit);
    end
endmodule

// File: rtl/plc_timer.sv
module plc_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             enable,
    input  logic             run_in,
    input  logic [CNT_W-1:0] preset,
    input  logic [1:0]       mode,
    output logic             done,
    output logic [CNT_W-1:0] elapsed
);
    import plc_timer_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
        logic             active;
    } tmr_state_t;

    tmr_state_t       st_d, st_q;
    tmr_mode_e        mode_e;
    logic             rise;
    logic [CNT_W-1:0] inc_cnt;
    logic             inc_hit;

    assign mode_e = tmr_mode_e'(mode);

    plc_timer_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (run_in),
        .rise  (rise)
    );

    plc_timer_satinc #(.CNT_W(CNT_W)) u_inc (
        .cnt      (st_q.cnt),
        .limit    (preset),
        .step     (tick),
        .nxt      (inc_cnt),
        .at_limit (inc_hit)
    );

    always_comb begin
        st_d = st_q;
        if (!enable) begin
            st_d = '0;
        end else begin
            unique case (mode_e)
                TM_ON_DLY: begin
                    st_d.active = 1'b0;
                    if (!run_in) begin
                        st_d.cnt  = '0;
                        st_d.done = 1'b0;
                    end else begin
                        st_d.cnt  = inc_cnt;
                        st_d.done = inc_hit;
                    end
                end
                TM_OFF_DLY: begin
                    st_d.active = 1'b0;
                    if (run_in) begin
                        st_d.cnt  = '0;
                        st_d.done = 1'b1;
                    end else if (st_q.done) begin
                        st_d.cnt  = inc_cnt;
                        st_d.done = ~inc_hit;
                    end
                end
                TM_PULSE: begin
                    if (rise && !st_q.active) begin
                        st_d.cnt    = '0;
                        st_d.active = (preset != '0);
                    end else if (st_q.active) begin
                        st_d.cnt    = inc_cnt;
                        st_d.active = ~inc_hit;
                    end
                    st_d.done = st_d.active;
                end
                TM_RETAIN: begin
                    st_d.active = 1'b0;
                    if (run_in) begin
                        st_d.cnt  = inc_cnt;
                        st_d.done = inc_hit;
                    end else begin
                        st_d.done = (st_q.cnt >= preset);
                    end
                end
                default: st_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done    = st_q.done;
    assign elapsed = st_q.cnt;

    // R1: disabled timer is cleared on the next edge
    a_r1_disabled_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (elapsed == '0) && !done);

    // R2: the count only moves on a tick, otherwise it holds or clears
    a_r2_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !tick) |=> (elapsed == $past(elapsed)) || (elapsed == '0));

    // R2: saturation at the preset
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (elapsed <= preset) |=> (elapsed <= $past(preset)));

    // R3: on-delay drops at once when the input is low
    a_r3_low_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && mode == 2'd0 && !run_in) |=> !done && (elapsed == '0));

    // R4: off-delay output is set while the input is high
    a_r4_high_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && mode == 2'd1 && run_in) |=> done);

    // R7: retentive count holds while the input is low
    a_r7_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && mode == 2'd3 && !run_in) |=> $stable(elapsed));
endmodule

// File: tb/plc_timer_tb.sv
`timescale 1ns/1ps
module plc_timer_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0;
    logic         enable = 1'b0;
    logic         run_in = 1'b0;
    logic [W-1:0] preset = '0;
    logic [1:0]   mode = 2'd0;
    logic         done;
    logic [W-1:0] elapsed;

    int checks = 0;
    int errors = 0;
    bit ended  = 1'b0;

    typedef struct {
        logic         done;
        logic [W-1:0] cnt;
        string        tag;
    } exp_t;

    exp_t sb_q[$];

    always #2 clk = ~clk;

    plc_timer #(.CNT_W(W)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .enable  (enable),
        .run_in  (run_in),
        .preset  (preset),
        .mode    (mode),
        .done    (done),
        .elapsed (elapsed)
    );

    task automatic step(input logic [1:0] m, input logic [W-1:0] p, input logic en,
                        input logic in, input logic tk, input logic ed,
                        input logic [W-1:0] ec, input string tag);
        exp_t e;
        @(negedge clk);
        mode = m; preset = p; enable = en; run_in = in; tick = tk;
        e.done = ed; e.cnt = ec; e.tag = tag;
        sb_q.push_back(e);
    endtask

    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (done !== e.done || elapsed !== e.cnt) begin
                errors++;
                $display("FAIL %s: done=%0b elapsed=%0d expected done=%0b elapsed=%0d",
                         e.tag, done, elapsed, e.done, e.cnt);
            end
        end
    end

    initial begin
        #20000;
        if (!ended) begin
            ended = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (done !== 1'b0 || elapsed !== '0) begin
            errors++;
            $display("FAIL R1 reset: done=%0b elapsed=%0d expected 0/0", done, elapsed);
        end
        rst_n = 1'b1;

        // R3 on-delay, preset 3
        step(0, 3, 1, 1, 1, 0, 1, "R3 count");
        step(0, 3, 1, 1, 0, 0, 1, "R2 no tick holds");
        step(0, 3, 1, 1, 1, 0, 2, "R3 count");
        step(0, 3, 1, 1, 1, 1, 3, "R3 done at preset");
        step(0, 3, 1, 1, 1, 1, 3, "R2 saturate");
        step(0, 3, 1, 0, 0, 0, 0, "R3 fall clears");
        step(0, 3, 1, 1, 1, 0, 1, "R3 short pulse");
        step(0, 3, 1, 1, 1, 0, 2, "R3 short pulse");
        step(0, 3, 1, 0, 1, 0, 0, "R3 short pulse no output");
        // R4 off-delay
        step(1, 3, 1, 1, 0, 1, 0, "R4 rise immediate");
        step(1, 3, 1, 0, 1, 1, 1, "R4 low counts");
        step(1, 3, 1, 0, 1, 1, 2, "R4 low counts");
        step(1, 3, 1, 1, 0, 1, 0, "R4 short gap keeps high");
        step(1, 3, 1, 0, 1, 1, 1, "R4 low counts");
        step(1, 3, 1, 0, 1, 1, 2, "R4 low counts");
        step(1, 3, 1, 0, 1, 0, 3, "R4 falls at preset");
        step(1, 3, 1, 0, 1, 0, 3, "R2 held after off");
        // R5/R6 fixed pulse
        step(2, 3, 1, 1, 0, 1, 0, "R5 pulse start");
        step(2, 3, 1, 0, 1, 1, 1, "R5 independent of input");
        step(2, 3, 1, 1, 1, 1, 2, "R6 retrigger ignored");
        step(2, 3, 1, 1, 1, 0, 3, "R5 pulse ends");
        step(2, 3, 1, 1, 1, 0, 3, "R5 no new pulse while high");
        step(2, 3, 1, 0, 0, 0, 3, "R5 hold");
        // R7 retentive
        step(3, 3, 0, 0, 0, 0, 0, "R1 disable clears");
        step(3, 3, 1, 1, 1, 0, 1, "R7 count");
        step(3, 3, 1, 0, 1, 0, 1, "R7 hold low");
        step(3, 3, 1, 0, 1, 0, 1, "R7 hold low");
        step(3, 3, 1, 1, 1, 0, 2, "R7 resume");
        step(3, 3, 1, 1, 1, 1, 3, "R7 done");
        step(3, 3, 1, 0, 0, 1, 3, "R7 stays done");
        step(3, 3, 0, 1, 1, 0, 0, "R1 only enable clears");
        step(0, 3, 0, 1, 1, 0, 0, "R1 no advance disabled");
        // R8 preset zero
        step(0, 0, 1, 1, 0, 1, 0, "R8 on-delay immediate");
        step(0, 0, 1, 0, 0, 0, 0, "R8 on-delay fall");
        step(1, 0, 1, 1, 0, 1, 0, "R8 off-delay rise");
        step(1, 0, 1, 0, 0, 0, 0, "R8 off-delay immediate fall");

        @(negedge clk);
        @(negedge clk);
        if (!ended) begin
            ended = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule